// File: doc/BRIEF.md
# Transmit Queue Scheduler

The scheduler sits between sixteen circular transmit descriptor queues and eight transmit FIFO channels. Each queue is tied by configuration to exactly one channel, and a channel may draw from several queues. Every cycle the block looks at the queues that have a descriptor waiting, keeps those that are switched on and still have room in their outstanding window, and forwards a single descriptor. It first picks the most important channel whose FIFO is ready, then the queue on that channel whose turn has come.

Each queue runs in one of two modes. In in-order mode only one descriptor may be outstanding, so the next one waits until the far end reports a completion. In window mode up to a configured frame limit may be outstanding, with the limit capped at 64. The command channel always runs in order. A completion pulse per queue returns one unit of window.

Top module: `tx_queue_sched`

## Requirements
- R1: After a synchronous active-low reset every queue is inactive with zero outstanding, and `q_gnt` and `ch_valid` are all zero.
- R2: A write with `cfg_we` high loads the word into queue `cfg_qid` at the clock edge, with effect from the next cycle. Bits [2:0] select the channel, bit 3 is the active flag, bit 19 selects window mode (1) over in-order mode (0), and bits [30:24] hold the frame limit.
- R3: A queue whose active flag is clear never receives a grant, whatever its request.
- R4: At most one queue is granted per cycle. A grant is given only while the ready input of the queue's channel is high. `ch_valid` then has the single bit of that channel set, and that channel's 4-bit field of `ch_qid` (bits c*4+3..c*4) carries the granted queue index.
- R5: Among channels that are ready and have an eligible queue, the winner is taken in the order 7, 3, 2, 1, 0, 6, 5, 4.
- R6: Within a channel, queues are served round-robin by index. After queue q is granted, the next search on that channel starts at q+1, wrapping from 15 to 0.
- R7: A queue in in-order mode is eligible only while it has zero descriptors outstanding.
- R8: A queue in window mode is eligible while its outstanding count is below its frame limit, with a limit above 64 treated as 64. A limit of 0 blocks the queue.
- R9: A queue mapped to channel 7 behaves as in-order mode whatever the value of bit 19.
- R10: A `q_done` pulse lowers the queue's outstanding count by one. A pulse with zero outstanding is ignored. A grant and a completion in the same cycle leave a nonzero count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 4 | Queue addressed by the write |
| cfg_word | input | 32 | Queue configuration word |
| q_req | input | 16 | Per-queue descriptor available |
| q_done | input | 16 | Per-queue completion pulse |
| q_gnt | output | 16 | Per-queue grant, one-hot or zero |
| ch_ready | input | 8 | Per-channel FIFO ready |
| ch_valid | output | 8 | Per-channel descriptor forwarded this cycle |
| ch_qid | output | 32 | Per-channel 4-bit queue index of the forwarded descriptor |

## Verification
The grant is combinational from registered state, so a wrong outstanding count, round-robin pointer or stored configuration shows at the ports in the first cycle where it changes eligibility. That appears as a grant that should not happen, a missing grant, or the wrong queue index. The bench keeps its own queue model and compares every output on every clock. Errors in window accounting therefore show up within a few cycles of a completion or a limit being reached, and not only at the end of a long burst.

// File: rtl/tqs_pkg.sv
// Shared constants, configuration type and channel ranking for the
// transmit queue scheduler. Assumes eight channels (3-bit channel field).
package tqs_pkg;
    localparam int CH_W      = 3;
    localparam int LIM_W     = 7;
    localparam int F_CH_LSB  = 0;
    localparam int F_ACT_BIT = 3;
    localparam int F_WIN_BIT = 19;
    localparam int F_LIM_LSB = 24;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic             active;
        logic             win;
        logic [LIM_W-1:0] lim;
    } qcfg_t;

    // Rank of a channel: command channel top, traffic classes 3..0 next,
    // remaining channels lowest. Zero is never a valid rank.
    function automatic logic [3:0] ch_rank(input int c, input int cmd);
        if (c == cmd)  return 4'd15;
        else if (c <= 3) return 4'(8 + c);
        else           return 4'(c);
    endfunction
endpackage

// File: rtl/tqs_queue_ctx.sv
// Per-queue context: stored configuration and outstanding-descriptor count.
// Produces the eligibility of the queue for the current cycle.
// Assumes gnt is only raised while elig is high.
module tqs_queue_ctx
    import tqs_pkg::*;
#(
    parameter int WIN_MAX = 64,
    parameter int CMD_CH  = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  qcfg_t           cfg_in,
    input  logic            req,
    input  logic            gnt,
    input  logic            done,
    output logic            elig,
    output logic [CH_W-1:0] ch
);
    localparam int OW = $clog2(WIN_MAX + 1);

    qcfg_t         cfg_q;
    logic [OW-1:0] outst;
    logic [OW-1:0] lim_eff;
    logic          dec;

    // Configuration register, cleared to inactive on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_in;
    end

    // Effective window: one in in-order mode or on the command channel.
    always_comb begin
        if (!cfg_q.win || cfg_q.ch == CH_W'(CMD_CH))
            lim_eff = OW'(1);
        else if (int'(cfg_q.lim) > WIN_MAX)
            lim_eff = OW'(WIN_MAX);
        else
            lim_eff = OW'(cfg_q.lim);
    end

    assign dec  = done && (outst != '0);
    assign elig = cfg_q.active && req && (outst < lim_eff);
    assign ch   = cfg_q.ch;

    // Outstanding counter: up on grant, down on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) outst <= '0;
        else        outst <= outst + OW'(gnt) - OW'(dec);
    end

    p_inactive_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> cfg_q.active);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (outst < lim_eff));
    p_cmd_inorder_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && cfg_q.ch == CH_W'(CMD_CH)) |-> (outst == '0));
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !gnt && outst == '0) |=> (outst == '0));
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q.active == $past(cfg_in.active)));
endmodule

// File: rtl/tqs_chan_rr.sv
// Round-robin picker for one channel: finds the first candidate queue at
// or after the stored pointer and advances the pointer past a served queue.
module tqs_chan_rr #(
    parameter int NQ = 16,
    parameter int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] cand,
    input  logic          take,
    output logic          any,
    output logic [QW-1:0] pick
);
    logic [QW-1:0] ptr;

    // Cyclic first-set search starting at the pointer.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < NQ; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NQ;
            if (!any && cand[idx]) begin
                any  = 1'b1;
                pick = QW'(idx);
            end
        end
    end

    // Pointer moves to the queue after the one just served.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (take) ptr <= (int'(pick) == NQ - 1) ? '0 : pick + QW'(1);
    end

    p_take_has_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (any && cand[pick]));
endmodule

// File: rtl/tqs_chan_sel.sv
// Fixed-priority channel selector: among channels that are ready and have
// an eligible queue, picks the one with the highest rank.
module tqs_chan_sel
    import tqs_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CMD_CH = 7,
    parameter int CW     = $clog2(NCH)
) (
    input  logic [NCH-1:0] ok,
    output logic           win_valid,
    output logic [CW-1:0]  win_ch
);
    // Highest-rank scan over all channels.
    always_comb begin
        logic [3:0] best;
        best      = '0;
        win_valid = 1'b0;
        win_ch    = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ok[c] && ch_rank(c, CMD_CH) > best) begin
                best      = ch_rank(c, CMD_CH);
                win_valid = 1'b1;
                win_ch    = CW'(c);
            end
        end
    end
endmodule

// File: rtl/tx_queue_sched.sv
// Transmit queue scheduler top: decodes configuration writes, holds one
// context per queue, one round-robin picker per channel and a channel
// priority selector; forwards at most one descriptor per cycle.
// Assumes q_done is pulsed once per completed descriptor.
module tx_queue_sched
    import tqs_pkg::*;
#(
    parameter int NQ      = 16,
    parameter int WIN_MAX = 64,
    parameter int CMD_CH  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NQ)-1:0]    cfg_qid,
    input  logic [31:0]              cfg_word,
    input  logic [NQ-1:0]            q_req,
    input  logic [NQ-1:0]            q_done,
    output logic [NQ-1:0]            q_gnt,
    input  logic [(1<<CH_W)-1:0]     ch_ready,
    output logic [(1<<CH_W)-1:0]     ch_valid,
    output logic [(1<<CH_W)*$clog2(NQ)-1:0] ch_qid
);
    localparam int NCH = 1 << CH_W;
    localparam int QW  = $clog2(NQ);

    qcfg_t           cfg_dec;
    logic [NQ-1:0]   elig;
    logic [CH_W-1:0] qch [NQ];
    logic [NQ-1:0]   cand [NCH];
    logic [NCH-1:0]  ch_any;
    logic [QW-1:0]   ch_pick [NCH];
    logic            win_valid;
    logic [CH_W-1:0] win_ch;
    logic            cfg_unused;

    // Field extraction from the configuration word.
    assign cfg_dec.ch     = cfg_word[F_CH_LSB +: CH_W];
    assign cfg_dec.active = cfg_word[F_ACT_BIT];
    assign cfg_dec.win    = cfg_word[F_WIN_BIT];
    assign cfg_dec.lim    = cfg_word[F_LIM_LSB +: LIM_W];
    assign cfg_unused     = ^{cfg_word[31], cfg_word[23:20], cfg_word[18:4]};

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        tqs_queue_ctx #(.WIN_MAX(WIN_MAX), .CMD_CH(CMD_CH)) i_ctx (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_we(cfg_we && cfg_qid == QW'(q)),
            .cfg_in(cfg_dec),
            .req   (q_req[q]),
            .gnt   (q_gnt[q]),
            .done  (q_done[q]),
            .elig  (elig[q]),
            .ch    (qch[q])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Candidate queues mapped onto this channel.
        always_comb begin
            for (int q = 0; q < NQ; q++)
                cand[c][q] = elig[q] && (qch[q] == CH_W'(c));
        end

        tqs_chan_rr #(.NQ(NQ), .QW(QW)) i_rr (
            .clk  (clk),
            .rst_n(rst_n),
            .cand (cand[c]),
            .take (win_valid && win_ch == CH_W'(c)),
            .any  (ch_any[c]),
            .pick (ch_pick[c])
        );

        assign ch_qid[c*QW +: QW] = ch_pick[c];
    end

    tqs_chan_sel #(.NCH(NCH), .CMD_CH(CMD_CH), .CW(CH_W)) i_sel (
        .ok       (ch_any & ch_ready),
        .win_valid(win_valid),
        .win_ch   (win_ch)
    );

    // One-hot grant and channel strobe from the winning channel.
    always_comb begin
        q_gnt    = '0;
        ch_valid = '0;
        if (win_valid) begin
            q_gnt[ch_pick[win_ch]] = 1'b1;
            ch_valid[win_ch]       = 1'b1;
        end
    end

    p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_gnt) && $onehot0(ch_valid));
    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_valid & ~ch_ready) == '0));
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q_gnt == '0));
endmodule

// File: tb/test_tx_queue_sched.sv
module test_tx_queue_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 16;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_qid = '0;
    logic [31:0] cfg_word = '0;
    logic [15:0] q_req = '0;
    logic [15:0] q_done = '0;
    logic [15:0] q_gnt;
    logic [7:0]  ch_ready = '0;
    logic [7:0]  ch_valid;
    logic [31:0] ch_qid;

    tx_queue_sched i_tx_queue_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
        .cfg_word(cfg_word), .q_req(q_req), .q_done(q_done), .q_gnt(q_gnt),
        .ch_ready(ch_ready), .ch_valid(ch_valid), .ch_qid(ch_qid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_ch[NQ], m_act[NQ], m_win[NQ], m_lim[NQ], m_out[NQ];
    int m_rr[NCH];
    int ord[8] = '{7, 3, 2, 1, 0, 6, 5, 4};
    int gcount[NQ];
    bit finished = 0;
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lim_of(int q);
        if (m_win[q] == 0 || m_ch[q] == 7) return 1;
        return (m_lim[q] > 64) ? 64 : m_lim[q];
    endfunction

    function automatic bit elig_of(int q);
        return m_act[q] != 0 && q_req[q] && m_out[q] < lim_of(q);
    endfunction

    function automatic logic [31:0] nxt();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    // Compare outputs with the model, then advance the model one clock.
    task automatic step(input string tag);
        int pick[NCH];
        bit anyc[NCH];
        int best;
        logic [15:0] eg;
        logic [7:0] ev;
        #1;
        for (int c = 0; c < NCH; c++) begin
            anyc[c] = 0; pick[c] = 0;
            for (int k = 0; k < NQ; k++) begin
                int q;
                q = (m_rr[c] + k) % NQ;
                if (!anyc[c] && elig_of(q) && m_ch[q] == c) begin
                    anyc[c] = 1; pick[c] = q;
                end
            end
        end
        best = -1;
        for (int i = 0; i < 8; i++)
            if (best < 0 && ch_ready[ord[i]] && anyc[ord[i]]) best = ord[i];
        eg = '0; ev = '0;
        if (best >= 0) begin eg[pick[best]] = 1'b1; ev[best] = 1'b1; end
        chk(q_gnt == eg, tag, "q_gnt", q_gnt, eg);
        chk(ch_valid == ev, tag, "ch_valid", ch_valid, ev);
        if (best >= 0)
            chk(ch_qid[best*4 +: 4] == 4'(pick[best]), tag, "ch_qid",
                ch_qid[best*4 +: 4], pick[best]);
        for (int q = 0; q < NQ; q++) begin
            int d;
            d = (q_done[q] && m_out[q] > 0) ? 1 : 0;
            if (q_gnt[q]) gcount[q]++;
            m_out[q] = m_out[q] + (eg[q] ? 1 : 0) - d;
        end
        if (best >= 0) m_rr[best] = (pick[best] + 1) % NQ;
        if (cfg_we) begin
            m_ch[cfg_qid]  = int'(cfg_word[2:0]);
            m_act[cfg_qid] = int'(cfg_word[3]);
            m_win[cfg_qid] = int'(cfg_word[19]);
            m_lim[cfg_qid] = int'(cfg_word[30:24]);
        end
        @(negedge clk);
    endtask

    task automatic cfgw(input int q, input int ch, input int act,
                        input int win, input int lim, input string tag);
        cfg_we   = 1'b1;
        cfg_qid  = 4'(q);
        cfg_word = 32'(ch) | (32'(act) << 3) | (32'(win) << 19) | (32'(lim) << 24);
        step(tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin
            m_ch[q] = 0; m_act[q] = 0; m_win[q] = 0; m_lim[q] = 0; m_out[q] = 0;
            gcount[q] = 0;
        end
        for (int c = 0; c < NCH; c++) m_rr[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R3: reset state, all requests up but nothing active.
        q_req = '1; ch_ready = '1;
        repeat (4) step("R1");
        repeat (2) step("R3");
        // R2 / R5 / R7: one in-order queue per traffic channel.
        for (int q = 0; q < 4; q++) cfgw(q, q, 1, 0, 0, "R2");
        repeat (6) step("R5");
        step("R7");
        // R10: completions including pulses on idle queues.
        q_done = 16'h00ff; step("R10");
        q_done = '0; repeat (3) step("R10");
        q_done = 16'h000f; step("R10");
        q_done = '0; step("R10");
        // R6: four window queues sharing channel 1.
        for (int q = 4; q < 8; q++) cfgw(q, 1, 1, 1, 3, "R6");
        q_req = 16'h00f0; repeat (14) step("R6");
        q_done = 16'h00f0; repeat (6) step("R6");
        q_done = '0;
        // R8: limit above 64 clamps; limit 0 blocks.
        for (int q = 0; q < NQ; q++) gcount[q] = 0;
        cfgw(8, 2, 1, 1, 127, "R8");
        cfgw(10, 2, 1, 1, 0, "R8");
        q_req = 16'h0500; repeat (70) step("R8");
        chk(gcount[8] == 64, "R8", "window grants", gcount[8], 64);
        chk(gcount[10] == 0, "R8", "zero-limit grants", gcount[10], 0);
        // R9: command channel ignores window bit.
        cfgw(9, 7, 1, 1, 20, "R9");
        q_req = 16'h0200; repeat (4) step("R9");
        q_done = 16'h0200; step("R9"); q_done = '0; repeat (3) step("R9");
        // R5: unused channels rank below traffic channels.
        cfgw(11, 4, 1, 0, 0, "R5"); cfgw(12, 6, 1, 0, 0, "R5");
        cfgw(13, 0, 1, 0, 0, "R5");
        q_req = 16'h3800; repeat (4) step("R5");
        q_done = '1; step("R5"); q_done = '0;
        // R4: ready gating, channel not ready.
        ch_ready = 8'h00; q_req = '1; repeat (3) step("R4");
        ch_ready = 8'h10; repeat (3) step("R4");
        // R4: randomised traffic, configuration and completions.
        ch_ready = '1;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = nxt();
            q_req = r[15:0]; ch_ready = r[23:16] | 8'h11;
            r = nxt();
            q_done = r[15:0] & nxt()[15:0];
            if (r[31:28] == 4'h0) begin
                logic [31:0] s;
                s = nxt();
                cfg_we = 1'b1; cfg_qid = s[3:0];
                cfg_word = {1'b0, s[10:4], 4'h0, s[11], 15'h0, (s[13:12] != 2'b00), s[16:14]};
            end
            step("R4");
            cfg_we = 1'b0;
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule